// File: doc/BRIEF.md
# XGMII Transmit Framer

This block turns frames offered on a 32-bit client packet stream into a 32-bit XGMII transmit word stream of four byte lanes plus four control bits. For each frame it sends a start character and preamble with delimiter. It then sends the client bytes, zero padding up to the minimum body length, and the CRC-32 check sequence. A terminate character closes the frame, and an inter-packet gap of idle characters follows. Idle characters fill the line whenever no frame is in progress, for as long as needed.

The client presents each word with its earliest byte in bits 31:24. XGMII carries the earliest byte on lane 0, in bits 7:0, so the block reverses the lane order of every word. Once a frame has started, the framer never pauses it. The client must therefore keep valid high from the start-of-packet word to the end-of-packet word. Ready is raised only while the body of a frame is being taken in.

Top module: `xgtx_framer`

## Requirements
- R1: Out of reset and between frames every lane carries 0x07 with its control bit set (txd = 0x07070707, txc = 4'b1111).
- R2: A frame opens with 0xFB on lane 0 with its control bit set, then six 0x55 bytes and one 0xD5 byte, all as data. A start character never appears on lanes 1 to 3.
- R3: Client bits 31:24 are the earliest frame byte and go out on lane 0 (txd bits 7:0). Bits 7:0 of the client word go out on lane 3.
- R4: A frame body shorter than 60 bytes is followed by zero bytes until the body reaches 60 bytes, ahead of the check sequence.
- R5: After the last data or pad byte come four check bytes, least significant byte first. They are the complement of a reflected CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF) taken over the data and pad bytes.
- R6: The byte after the check sequence is 0xFD with its control bit set. The lanes after it in the same word carry 0x07 with control set.
- R7: Once the start character is sent, every byte up to the terminate character is a frame byte with no idle between. Ready stays high from the start-of-packet word until the end-of-packet word is taken. The client keeps valid high over that span, and the first word taken carries start-of-packet.
- R8: From the terminate character to the next start character there are at least 12 byte times, terminate included. When the next frame is already waiting, it starts in the first word that meets this limit, so the gap is at most 15 byte times.
- R9: Outside a frame body ready is low, and client data, valid without start-of-packet, and junk bytes have no effect on the line.
- R10: On the end-of-packet word, the 2-bit empty field gives the number of unused bytes (0 to 3). These are the least significant bytes of the word, and they never reach the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both interfaces |
| rst_n | input | 1 | Synchronous reset, active low |
| cl_valid | input | 1 | Client word valid |
| cl_ready | output | 1 | Framer takes the client word this cycle |
| cl_data | input | 32 | Client word, earliest byte in bits 31:24 |
| cl_sop | input | 1 | Word is the first of a frame |
| cl_eop | input | 1 | Word is the last of a frame |
| cl_empty | input | 2 | Unused low-order bytes in the end-of-packet word |
| xg_txd | output | 32 | XGMII transmit data, lane 0 in bits 7:0 |
| xg_txc | output | 4 | XGMII transmit control, one bit per lane |

## Verification
The bench sends frames of 1, 7, 59, 60, 61 to 65, 100 and 128 bytes. These lengths put the terminate character on every lane and split the check sequence across two words. A framer that miscounted the pad boundary would stop the body at the wrong byte. One that computed the check over the wrong bytes, or that lost the partial check held over from the previous word, would emit wrong check bytes. Back-to-back frames expose a gap counter that is off by one word: it would show a gap under 12 or over 15 byte times. Junk in unused lanes and stray valid words between frames would leak onto the line if either the empty field or the idle-time ready were decoded wrongly.

// File: rtl/xgtx_pkg.sv
// Package: shared constants, lane classification type and the CRC-32 byte step
// used by the XGMII transmit framer. Assumes the 4-lane, 32-bit XGMII layout.
package xgtx_pkg;

    localparam int LANES     = 4;
    localparam int DW        = LANES * 8;
    localparam int FCS_BYTES = 4;

    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_PRE   = 8'h55;
    localparam logic [7:0] CH_SFD   = 8'hD5;

    localparam logic [31:0] CRC_REFL_POLY = 32'hEDB88320;

    // What a given output lane carries inside the body phase of a frame
    typedef enum logic [2:0] {
        K_DATA,
        K_PAD,
        K_FCS,
        K_TERM,
        K_IDLE
    } lane_kind_e;

    // Folds one byte into a reflected CRC-32 register, LSB first
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_REFL_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/xgtx_lane_class.sv
// Module: decides what one output lane carries during the body phase, from the
// byte index of that lane and the data length (all ones while still unknown).
// Assumes body order data, zero pad to MIN_BODY, check bytes, terminate.
module xgtx_lane_class
    import xgtx_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MIN_BODY = 60,
    parameter int LANE     = 0
) (
    input  logic [LEN_W-1:0] pos,
    input  logic [LEN_W-1:0] eff_len,
    output lane_kind_e       kind,
    output logic [1:0]       fcs_idx
);

    localparam int XW = LEN_W + 2;

    logic [XW-1:0] b_idx;
    logic [XW-1:0] data_end;
    logic [XW-1:0] pad_end;
    logic [XW-1:0] fcs_off;

    assign b_idx    = XW'(pos) + XW'(LANE);
    assign data_end = XW'(eff_len);
    assign pad_end  = (data_end < XW'(MIN_BODY)) ? XW'(MIN_BODY) : data_end;
    assign fcs_off  = b_idx - pad_end;

    // Purpose: place this byte index in the data/pad/check/terminate/idle order
    always_comb begin
        fcs_idx = fcs_off[1:0];
        if (b_idx < data_end) begin
            kind = K_DATA;
        end else if (b_idx < pad_end) begin
            kind = K_PAD;
        end else if (b_idx < pad_end + XW'(FCS_BYTES)) begin
            kind = K_FCS;
        end else if (b_idx == pad_end + XW'(FCS_BYTES)) begin
            kind = K_TERM;
        end else begin
            kind = K_IDLE;
        end
    end

endmodule

// File: rtl/xgtx_crc_word.sv
// Module: advances a reflected CRC-32 over the enabled lanes of one word, lane 0
// first. Assumes enabled lanes form a prefix of the word, as data and pad do.
module xgtx_crc_word
    import xgtx_pkg::*;
#(
    parameter int NL = 4
) (
    input  logic [31:0]     crc_in,
    input  logic [NL*8-1:0] lane_bytes,
    input  logic [NL-1:0]   en,
    output logic [31:0]     crc_out
);

    // Purpose: chain the byte step through the enabled lanes in link order
    always_comb begin
        logic [31:0] c;
        c = crc_in;
        for (int g = 0; g < NL; g++) begin
            if (en[g]) begin
                c = crc32_byte(c, lane_bytes[8*g +: 8]);
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/xgtx_framer.sv
// Module: XGMII transmit framer. Takes big-endian client words, emits start,
// preamble, body with zero pad, CRC-32 check, terminate and inter-packet gap.
// Assumes the client holds valid from SOP to EOP and starts frames word-aligned.
module xgtx_framer
    import xgtx_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_BODY  = 60,
    parameter int IPG_BYTES = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cl_valid,
    output logic          cl_ready,
    input  logic [DW-1:0] cl_data,
    input  logic          cl_sop,
    input  logic          cl_eop,
    input  logic [1:0]    cl_empty,
    output logic [DW-1:0] xg_txd,
    output logic [LANES-1:0] xg_txc
);

    localparam int LW    = $clog2(LANES);
    localparam int GAP_W = $clog2(IPG_BYTES / LANES + 2);

    localparam logic [DW-1:0] IDLE_WORD = {LANES{CH_IDLE}};
    localparam logic [DW-1:0] PRE0_WORD = {CH_PRE, CH_PRE, CH_PRE, CH_START};
    localparam logic [DW-1:0] PRE1_WORD = {CH_SFD, CH_PRE, CH_PRE, CH_PRE};

    typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_BODY} st_e;

    st_e              st_q, st_d;
    logic [LEN_W-1:0] pos_q, len_q;
    logic             done_q;
    logic [GAP_W-1:0] gap_q, gap_load;
    logic [31:0]      crc_q, crc_mid, fcs;
    logic             taking;
    logic [LEN_W-1:0] nvalid, eff_len;
    logic [DW-1:0]    link_bytes, crc_bytes, body_txd, nxt_txd;
    logic [LANES-1:0] crc_en, body_txc, nxt_txc;
    lane_kind_e       kind [LANES];
    logic [1:0]       fidx [LANES];
    logic             term_hit;
    logic [LW-1:0]    term_lane;

    assign taking   = (st_q == ST_BODY) && !done_q;
    assign cl_ready = taking;
    assign nvalid   = LEN_W'(LANES) - LEN_W'(cl_empty);
    assign eff_len  = done_q ? len_q : ((taking && cl_eop) ? pos_q + nvalid : '1);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Purpose: reverse client byte order into link (lane) order
            assign link_bytes[8*g +: 8] = cl_data[DW-1-8*g -: 8];

            xgtx_lane_class #(
                .LEN_W   (LEN_W),
                .MIN_BODY(MIN_BODY),
                .LANE    (g)
            ) u_class (
                .pos    (pos_q),
                .eff_len(eff_len),
                .kind   (kind[g]),
                .fcs_idx(fidx[g])
            );

            assign crc_en[g] = (kind[g] == K_DATA) || (kind[g] == K_PAD);
            assign crc_bytes[8*g +: 8] = (kind[g] == K_DATA) ? link_bytes[8*g +: 8] : 8'h00;

            // Purpose: select the byte and control bit this lane sends in the body
            always_comb begin
                case (kind[g])
                    K_DATA:  begin body_txd[8*g +: 8] = link_bytes[8*g +: 8]; body_txc[g] = 1'b0; end
                    K_PAD:   begin body_txd[8*g +: 8] = 8'h00;                body_txc[g] = 1'b0; end
                    K_FCS:   begin body_txd[8*g +: 8] = fcs[8*fidx[g] +: 8];  body_txc[g] = 1'b0; end
                    K_TERM:  begin body_txd[8*g +: 8] = CH_TERM;              body_txc[g] = 1'b1; end
                    default: begin body_txd[8*g +: 8] = CH_IDLE;              body_txc[g] = 1'b1; end
                endcase
            end
        end
    endgenerate

    xgtx_crc_word #(.NL(LANES)) u_crc (
        .crc_in    (crc_q),
        .lane_bytes(crc_bytes),
        .en        (crc_en),
        .crc_out   (crc_mid)
    );

    assign fcs = ~crc_mid;

    // Purpose: find the lowest lane holding terminate and size the following gap
    always_comb begin
        term_hit  = 1'b0;
        term_lane = '0;
        for (int g = LANES - 1; g >= 0; g--) begin
            if (kind[g] == K_TERM) begin
                term_hit  = 1'b1;
                term_lane = LW'(g);
            end
        end
        gap_load = GAP_W'((IPG_BYTES - 1 + int'(term_lane)) / LANES);
    end

    // Purpose: next line word and next state of the frame sequencer
    always_comb begin
        st_d    = st_q;
        nxt_txd = IDLE_WORD;
        nxt_txc = '1;
        case (st_q)
            ST_IDLE: begin
                if (gap_q == '0 && cl_valid && cl_sop) begin
                    nxt_txd = PRE0_WORD;
                    nxt_txc = 4'b0001;
                    st_d    = ST_PRE;
                end
            end
            ST_PRE: begin
                nxt_txd = PRE1_WORD;
                nxt_txc = '0;
                st_d    = ST_BODY;
            end
            default: begin
                nxt_txd = body_txd;
                nxt_txc = body_txc;
                if (term_hit) st_d = ST_IDLE;
            end
        endcase
    end

    // Purpose: register line outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            xg_txd <= IDLE_WORD;
            xg_txc <= '1;
            pos_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
            gap_q  <= '0;
            crc_q  <= '1;
        end else begin
            st_q   <= st_d;
            xg_txd <= nxt_txd;
            xg_txc <= nxt_txc;
            if (st_q == ST_PRE) begin
                pos_q  <= '0;
                done_q <= 1'b0;
                crc_q  <= '1;
            end else if (st_q == ST_BODY) begin
                pos_q <= pos_q + LEN_W'(LANES);
                crc_q <= crc_mid;
                if (taking && cl_eop) begin
                    done_q <= 1'b1;
                    len_q  <= eff_len;
                end
                if (term_hit) gap_q <= gap_load;
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    // Client keeps valid up while the body is taken in
    assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cl_ready |-> cl_valid);

    // First body word taken must carry start-of-packet
    assert_sop_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (taking && pos_q == '0) |-> cl_sop);

    // No control character appears mid-body
    assert_no_ctrl_in_body_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY && !term_hit) |=> (xg_txc == '0));

    // Start word precedes the preamble tail
    assert_start_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRE) |-> (xg_txd == PRE0_WORD && xg_txc == 4'b0001));

    // Gap words stay idle while the counter runs
    assert_gap_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && gap_q != '0) |=> (xg_txd == IDLE_WORD && xg_txc == '1));

    // Terminate never comes before a padded body plus check sequence
    assert_min_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY && term_hit) |->
            ((32'(pos_q) + 32'(term_lane)) >= 32'(MIN_BODY + FCS_BYTES)));

endmodule

// File: tb/xgtx_framer_bench.sv
module xgtx_framer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cl_valid = 1'b0;
    logic        cl_ready;
    logic [31:0] cl_data = 32'h0;
    logic        cl_sop = 1'b0;
    logic        cl_eop = 1'b0;
    logic [1:0]  cl_empty = 2'd0;
    logic [31:0] xg_txd;
    logic [3:0]  xg_txc;

    always #4 clk = ~clk;

    xgtx_framer u_xgtx_framer (
        .clk(clk), .rst_n(rst_n), .cl_valid(cl_valid), .cl_ready(cl_ready),
        .cl_data(cl_data), .cl_sop(cl_sop), .cl_eop(cl_eop), .cl_empty(cl_empty),
        .xg_txd(xg_txd), .xg_txc(xg_txc)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [8:0] exp_q [$];
    int         tag_q [$];
    bit         tight_q [$];
    bit         mon_on = 1'b0;
    bit         in_frame = 1'b0;
    bit         seen = 1'b0;
    int         gap_bytes = 0;
    logic [8:0] got;
    logic [8:0] e;
    int         etag;
    bit         tight;

    function automatic string tname(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    // Driver: builds the expected line bytes, then offers the frame word by word
    task automatic send_frame(input int len, input int seed, input bit is_tight);
        logic [7:0]  fb [$];
        logic [31:0] crc;
        logic [31:0] w;
        int nw;
        int body;
        for (int k = 0; k < len; k++) fb.push_back(8'((seed * 31 + k * 7 + 3) & 255));
        tight_q.push_back(is_tight);
        exp_q.push_back(9'h1FB); tag_q.push_back(2);
        for (int k = 0; k < 6; k++) begin exp_q.push_back(9'h055); tag_q.push_back(2); end
        exp_q.push_back(9'h0D5); tag_q.push_back(2);
        crc = 32'hFFFFFFFF;
        body = (len < 60) ? 60 : len;
        for (int k = 0; k < body; k++) begin
            logic [7:0] bv;
            bv = (k < len) ? fb[k] : 8'h00;
            crc = crc_step(crc, bv);
            exp_q.push_back({1'b0, bv}); tag_q.push_back((k < len) ? 3 : 4);
        end
        crc = ~crc;
        for (int k = 0; k < 4; k++) begin exp_q.push_back({1'b0, crc[8*k +: 8]}); tag_q.push_back(5); end
        exp_q.push_back(9'h1FD); tag_q.push_back(6);
        nw = (len + 3) / 4;
        for (int i = 0; i < nw; i++) begin
            for (int j = 0; j < 4; j++) begin
                w[31 - 8*j -: 8] = (4*i + j < len) ? fb[4*i + j] : 8'hAA;
            end
            cl_valid = 1'b1;
            cl_data  = w;
            cl_sop   = (i == 0);
            cl_eop   = (i == nw - 1);
            cl_empty = (i == nw - 1) ? 2'(4*nw - len) : 2'd0;
            while (!cl_ready) @(negedge clk);
            @(negedge clk);
        end
        cl_valid = 1'b0; cl_sop = 1'b0; cl_eop = 1'b0; cl_empty = 2'd0;
        cl_data  = 32'hDEADBEEF;
    endtask

    // Monitor: walks the line byte by byte and scores against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            for (int l = 0; l < 4; l++) begin
                got = {xg_txc[l], xg_txd[8*l +: 8]};
                if (!in_frame) begin
                    if (got == 9'h107) begin
                        gap_bytes++;
                    end else if (got == 9'h1FB) begin
                        chk(l == 0, "R2 start lane", 32'(l), 32'd0);
                        if (seen) begin
                            tight = tight_q.pop_front();
                            chk(gap_bytes >= 12, "R8 gap min", 32'(gap_bytes), 32'd12);
                            if (tight) chk(gap_bytes <= 15, "R8 gap max", 32'(gap_bytes), 32'd15);
                        end else begin
                            tight = tight_q.pop_front();
                        end
                        seen = 1'b1;
                        in_frame = 1'b1;
                    end else begin
                        chk(1'b0, "R1 R9 idle between frames", 32'(got), 32'h107);
                    end
                end
                if (in_frame) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected byte", 32'(got), 32'h0);
                        in_frame = 1'b0;
                    end else begin
                        e = exp_q.pop_front();
                        etag = tag_q.pop_front();
                        chk(got == e, tname(etag), 32'(got), 32'(e));
                        if (e == 9'h1FD) begin
                            in_frame = 1'b0;
                            gap_bytes = 1;
                        end
                    end
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure with the summary line
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL R7 watchdog act=%0d exp=done", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xg_txd == 32'h07070707, "R1 reset data", xg_txd, 32'h07070707);
        chk(xg_txc == 4'hF, "R1 reset ctrl", 32'(xg_txc), 32'hF);
        chk(cl_ready == 1'b0, "R9 reset ready", 32'(cl_ready), 32'd0);
        mon_on = 1'b1;
        // R3 R4 R5 R6 R10: lengths landing terminate on every lane, back to back (R8)
        send_frame(1, 1, 1'b0);
        send_frame(7, 2, 1'b1);
        send_frame(59, 3, 1'b1);
        send_frame(60, 4, 1'b1);
        send_frame(61, 5, 1'b1);
        send_frame(62, 6, 1'b1);
        send_frame(63, 7, 1'b1);
        send_frame(64, 8, 1'b1);
        send_frame(65, 9, 1'b1);
        send_frame(100, 10, 1'b1);
        send_frame(128, 11, 1'b1);
        // R9: stray valid words without SOP and junk data while idle
        cl_valid = 1'b1; cl_sop = 1'b0; cl_data = 32'h12345678;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(cl_ready == 1'b0, "R9 ready idle", 32'(cl_ready), 32'd0);
        end
        send_frame(61, 12, 1'b0);
        repeat (7) @(negedge clk);
        send_frame(66, 13, 1'b0);
        while (exp_q.size() != 0 || in_frame) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(xg_txc == 4'hF && xg_txd == 32'h07070707, "R1 idle after", xg_txd, 32'h07070707);
        chk(tight_q.size() == 0, "R7 frames seen", 32'(tight_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule